// File: doc/BRIEF.md
# PCM Highway Voice Slot Port

This block attaches one voice channel to a serial time-division PCM highway. A frame-sync pulse sampled on a rising PCM clock edge opens a frame. In its programmed transmit slot the port shifts a voice sample onto the transmit line, most significant bit first. It also drives an output-enable and an active-low busy signal for exactly those bit periods, so other devices can share the line outside the slot. In its programmed receive slot it gathers the bits from the receive line and presents the sample on a parallel output with a one-cycle strobe.

The port runs on a fast system clock. The PCM clock, frame sync and receive line are treated as slow inputs: they are synchronized and edge-detected inside the block. Each bit spans one PCM clock period, or two periods in double-rate mode. Slots are 8 bits wide for companded samples. A linear test mode widens the window to 16 bits over two neighbouring slots. The slot numbers, modes and transmit sample are taken at the frame-sync bit and hold for the whole frame.

Top module: `pcm_voice_port`

## Requirements
- R1: A frame starts when frame_sync is high at a PCM clock rising edge. That edge begins bit 0 of slot 0. Until the first frame sync, the port never drives the line and never strobes.
- R2: In the transmit window, tx_line carries the latched sample MSB first, one bit per bit period. The window begins at frame bit tx_slot_sel*8. tx_line changes only at a bit start.
- R3: tx_busy_n is low exactly when tx_line_oe is high. tx_line_oe is high only in the transmit window. Outside it, tx_line is 0.
- R4: In the receive window, bits from rx_line are shifted in MSB first. One system cycle after the last bit is sampled, rx_sample holds the word and rx_strobe is high for exactly one cycle.
- R5: With dbl_rate=0, each PCM clock period is one bit, and rx_line is sampled on its falling edge.
- R6: With dbl_rate=1, each bit spans two PCM clock periods. The bit starts on the first rising edge, and rx_line is sampled on the second falling edge. The value on the first falling edge is ignored.
- R7: With lin_mode=1, the window is 16 bits over slot N and slot N+1, and all 16 bits of tx_sample are sent. With lin_mode=0, the window is 8 bits, tx_sample[7:0] is sent, and rx_sample[15:8] reads 0.
- R8: A direction is disabled for the frame when its slot is 32 or more (MAX_SLOTS). In linear mode it is also disabled when slot+1 is 32 or more. A disabled direction gives no output-enable and no strobe.
- R9: tx_sample, both slot numbers, dbl_rate and lin_mode are latched at the frame-sync bit. Changes made later in the frame take effect only at the next frame.
- R10: After reset, tx_line_oe=0, tx_busy_n=1, tx_line=0 and rx_strobe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_clk | input | 1 | Highway bit clock (slow, synchronized inside) |
| frame_sync | input | 1 | Frame start marker, sampled on PCM rising edges |
| rx_line | input | 1 | Serial receive data from the highway |
| dbl_rate | input | 1 | 1: two PCM clock periods per bit |
| lin_mode | input | 1 | 1: 16-bit linear samples over two slots |
| tx_slot_sel | input | 6 | Transmit slot index |
| rx_slot_sel | input | 6 | Receive slot index |
| tx_sample | input | 16 | Sample to send, latched at frame start |
| tx_line | output | 1 | Serial transmit data |
| tx_line_oe | output | 1 | High while the port drives tx_line |
| tx_busy_n | output | 1 | Active-low transmit-in-progress |
| rx_sample | output | 16 | Last received sample |
| rx_strobe | output | 1 | One-cycle pulse when rx_sample is new |

## Verification
In double-rate mode the bench puts the inverse of each receive bit on the line during the first PCM period. A port that samples on the first falling edge would then return the bit-wise complement of the word. The bench tests slots at both ends of the range: the last slot of the frame, and a linear window whose second slot falls off the end. An off-by-one range check would either drop the last valid slot or drive a window that runs off the frame. The transmit sample and slot are rewritten in the middle of a frame. A port that does not latch at frame sync would send a corrupted byte or move its window. The bench also clocks the highway with no frame sync, where a port with a free-running counter would start transmitting.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

   // A direction is usable when its whole window fits inside the slot range.
   function automatic logic win_on(input int unsigned slot, input logic lin,
                                   input int unsigned maxs);
      return lin ? (slot + 1 < maxs) : (slot < maxs);
   endfunction

   function automatic logic win_hit(input int unsigned bitc, input int unsigned slot,
                                    input logic lin, input int unsigned maxs,
                                    input int unsigned cw);
      int unsigned first, len;
      first = slot * cw;
      len   = lin ? 2 * cw : cw;
      return win_on(slot, lin, maxs) && (bitc >= first) && (bitc < first + len);
   endfunction

   function automatic int unsigned win_off(input int unsigned bitc, input int unsigned slot,
                                           input int unsigned cw);
      return bitc - slot * cw;
   endfunction

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pclk_in,
   input  logic fs_in,
   input  logic rxd_in,
   output logic pclk_rise,
   output logic pclk_fall,
   output logic fs_s,
   output logic rxd_s
);
   localparam int W = 3;

   logic [W-1:0] last;
   logic         pclk_p;

   generate
      if (STAGES == 1) begin : g_one
         logic [W-1:0] q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= '0;
            else        q <= {pclk_in, fs_in, rxd_in};
         assign last = q;
      end else begin : g_many
         logic [W*STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= '0;
            else        q <= {q[W*(STAGES-1)-1:0], pclk_in, fs_in, rxd_in};
         assign last = q[W*STAGES-1 -: W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pclk_p <= 1'b0;
      else        pclk_p <= last[2];

   assign pclk_rise = last[2] & ~pclk_p;
   assign pclk_fall = ~last[2] & pclk_p;
   assign fs_s      = last[1];
   assign rxd_s     = last[0];
endmodule

// File: rtl/pcm_bit_timer.sv
module pcm_bit_timer #(
   parameter int MAX_SLOTS = 32,
   parameter int COMP_W    = 8,
   parameter int SLOT_W    = 6,
   parameter int BIT_W     = 9,
   parameter int LIN_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pclk_rise,
   input  logic              pclk_fall,
   input  logic              fs_s,
   input  logic              cfg_double,
   input  logic              cfg_linear,
   input  logic [SLOT_W-1:0] tx_slot,
   input  logic [SLOT_W-1:0] rx_slot,
   input  logic [LIN_W-1:0]  tx_word,
   output logic              bit_go,
   output logic              cap_go,
   output logic [BIT_W-1:0]  bitcnt,
   output logic              lin_q,
   output logic [SLOT_W-1:0] tx_slot_q,
   output logic [SLOT_W-1:0] rx_slot_q,
   output logic [LIN_W-1:0]  tx_word_q
);
   localparam logic [BIT_W-1:0] END_BIT = BIT_W'(MAX_SLOTS * COMP_W);

   logic dbl_q;
   logic ph;   // 1: the next rising edge is the second period of a double-rate bit

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt    <= END_BIT;
         ph        <= 1'b0;
         bit_go    <= 1'b0;
         cap_go    <= 1'b0;
         dbl_q     <= 1'b0;
         lin_q     <= 1'b0;
         tx_slot_q <= '0;
         rx_slot_q <= '0;
         tx_word_q <= '0;
      end else begin
         bit_go <= 1'b0;
         cap_go <= 1'b0;
         if (pclk_rise) begin
            if (fs_s) begin
               bitcnt    <= '0;
               ph        <= cfg_double;
               bit_go    <= 1'b1;
               dbl_q     <= cfg_double;
               lin_q     <= cfg_linear;
               tx_slot_q <= tx_slot;
               rx_slot_q <= rx_slot;
               tx_word_q <= tx_word;
            end else begin
               if (!dbl_q || !ph) begin
                  bit_go <= 1'b1;
                  if (bitcnt != END_BIT) bitcnt <= bitcnt + BIT_W'(1);
               end
               ph <= dbl_q ? ~ph : 1'b0;
            end
         end
         if (pclk_fall && (!dbl_q || !ph) && (bitcnt != END_BIT))
            cap_go <= 1'b1;
      end
   end
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
   import pcm_port_pkg::*;
#(
   parameter int MAX_SLOTS = 32,
   parameter int COMP_W    = 8,
   parameter int SLOT_W    = 6,
   parameter int BIT_W     = 9,
   parameter int LIN_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_go,
   input  logic [BIT_W-1:0]  bitcnt,
   input  logic              lin_q,
   input  logic [SLOT_W-1:0] slot_q,
   input  logic [LIN_W-1:0]  word_q,
   output logic              tx_line,
   output logic              tx_oe,
   output logic              tx_busy_n
);
   localparam int IDX_W = $clog2(LIN_W);

   logic hit, bit_val;

   always_comb begin
      int unsigned len, off;
      len     = lin_q ? LIN_W : COMP_W;
      off     = win_off(32'(bitcnt), 32'(slot_q), COMP_W);
      hit     = win_hit(32'(bitcnt), 32'(slot_q), lin_q, MAX_SLOTS, COMP_W);
      bit_val = hit ? word_q[IDX_W'(len - 1 - off)] : 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_line   <= 1'b0;
         tx_oe     <= 1'b0;
         tx_busy_n <= 1'b1;
      end else if (bit_go) begin
         tx_line   <= bit_val;
         tx_oe     <= hit;
         tx_busy_n <= ~hit;
      end
   end
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
   import pcm_port_pkg::*;
#(
   parameter int MAX_SLOTS = 32,
   parameter int COMP_W    = 8,
   parameter int SLOT_W    = 6,
   parameter int BIT_W     = 9,
   parameter int LIN_W     = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_go,
   input  logic              rxd_s,
   input  logic [BIT_W-1:0]  bitcnt,
   input  logic              lin_q,
   input  logic [SLOT_W-1:0] slot_q,
   output logic [LIN_W-1:0]  rx_word,
   output logic              rx_valid
);
   logic             rxd_d;
   logic [LIN_W-1:0] sr, full;
   logic             hit, last_bit;

   always_comb begin
      int unsigned len;
      len      = lin_q ? LIN_W : COMP_W;
      hit      = win_hit(32'(bitcnt), 32'(slot_q), lin_q, MAX_SLOTS, COMP_W);
      last_bit = hit && (win_off(32'(bitcnt), 32'(slot_q), COMP_W) == len - 1);
      full     = {sr[LIN_W-2:0], rxd_d};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxd_d    <= 1'b0;
         sr       <= '0;
         rx_word  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rxd_d    <= rxd_s;
         rx_valid <= 1'b0;
         if (cap_go && hit) begin
            sr <= full;
            if (last_bit) begin
               rx_word  <= lin_q ? full : {{(LIN_W-COMP_W){1'b0}}, full[COMP_W-1:0]};
               rx_valid <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port #(
   parameter int MAX_SLOTS   = 32,
   parameter int COMP_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SLOT_W      = $clog2(MAX_SLOTS) + 1,
   parameter int LIN_W       = 2 * COMP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pcm_clk,
   input  logic              frame_sync,
   input  logic              rx_line,
   input  logic              dbl_rate,
   input  logic              lin_mode,
   input  logic [SLOT_W-1:0] tx_slot_sel,
   input  logic [SLOT_W-1:0] rx_slot_sel,
   input  logic [LIN_W-1:0]  tx_sample,
   output logic              tx_line,
   output logic              tx_line_oe,
   output logic              tx_busy_n,
   output logic [LIN_W-1:0]  rx_sample,
   output logic              rx_strobe
);
   localparam int BIT_W = $clog2(MAX_SLOTS * COMP_W) + 1;

   initial begin
      assert (MAX_SLOTS >= 2 && COMP_W >= 2 && SYNC_STAGES >= 1)
         else $error("pcm_voice_port: bad parameters");
      assert ((1 << (SLOT_W - 1)) >= MAX_SLOTS)
         else $error("pcm_voice_port: SLOT_W cannot express out-of-range slots");
   end

   logic              pclk_rise, pclk_fall, fs_s, rxd_s;
   logic              bit_go, cap_go, lin_q;
   logic [BIT_W-1:0]  bitcnt;
   logic [SLOT_W-1:0] tx_slot_q, rx_slot_q;
   logic [LIN_W-1:0]  tx_word_q;

   pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pclk_in(pcm_clk), .fs_in(frame_sync), .rxd_in(rx_line),
      .pclk_rise(pclk_rise), .pclk_fall(pclk_fall), .fs_s(fs_s), .rxd_s(rxd_s));

   pcm_bit_timer #(.MAX_SLOTS(MAX_SLOTS), .COMP_W(COMP_W), .SLOT_W(SLOT_W),
                   .BIT_W(BIT_W), .LIN_W(LIN_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .pclk_rise(pclk_rise), .pclk_fall(pclk_fall),
      .fs_s(fs_s), .cfg_double(dbl_rate), .cfg_linear(lin_mode),
      .tx_slot(tx_slot_sel), .rx_slot(rx_slot_sel), .tx_word(tx_sample),
      .bit_go(bit_go), .cap_go(cap_go), .bitcnt(bitcnt), .lin_q(lin_q),
      .tx_slot_q(tx_slot_q), .rx_slot_q(rx_slot_q), .tx_word_q(tx_word_q));

   pcm_tx_lane #(.MAX_SLOTS(MAX_SLOTS), .COMP_W(COMP_W), .SLOT_W(SLOT_W),
                 .BIT_W(BIT_W), .LIN_W(LIN_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .bit_go(bit_go), .bitcnt(bitcnt), .lin_q(lin_q),
      .slot_q(tx_slot_q), .word_q(tx_word_q),
      .tx_line(tx_line), .tx_oe(tx_line_oe), .tx_busy_n(tx_busy_n));

   pcm_rx_lane #(.MAX_SLOTS(MAX_SLOTS), .COMP_W(COMP_W), .SLOT_W(SLOT_W),
                 .BIT_W(BIT_W), .LIN_W(LIN_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .cap_go(cap_go), .rxd_s(rxd_s), .bitcnt(bitcnt),
      .lin_q(lin_q), .slot_q(rx_slot_q), .rx_word(rx_sample), .rx_valid(rx_strobe));
endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk #(
   parameter int MAX_SLOTS = 32,
   parameter int SLOT_W    = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_line,
   input logic              tx_line_oe,
   input logic              tx_busy_n,
   input logic              rx_strobe,
   input logic              bit_go,
   input logic              cap_go,
   input logic              lin_q,
   input logic [SLOT_W-1:0] tx_slot_q,
   input logic [SLOT_W-1:0] rx_slot_q
);
   function automatic logic in_range(input logic [SLOT_W-1:0] s, input logic lin);
      return lin ? (32'(s) + 1 < MAX_SLOTS) : (32'(s) < MAX_SLOTS);
   endfunction

   p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_line_oe |-> !tx_line);

   p_busy_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy_n == !tx_line_oe);

   p_hold_between_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_go |=> ($stable(tx_line) && $stable(tx_line_oe)));

   p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> !rx_strobe);

   p_strobe_after_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |-> $past(cap_go));

   p_tx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_line_oe) |-> in_range(tx_slot_q, lin_q));

   p_rx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |-> in_range(rx_slot_q, lin_q));
endmodule

bind pcm_voice_port pcm_voice_port_chk #(.MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_line(tx_line), .tx_line_oe(tx_line_oe),
   .tx_busy_n(tx_busy_n), .rx_strobe(rx_strobe), .bit_go(bit_go), .cap_go(cap_go),
   .lin_q(lin_q), .tx_slot_q(tx_slot_q), .rx_slot_q(rx_slot_q));

// File: tb/tb_pcm_voice_port.sv
`timescale 1ns/1ps
module tb_pcm_voice_port;
   localparam int MAXS = 32;
   localparam int HALF = 8;   // system clocks per PCM half period

   logic clk = 1'b0, rst_n = 1'b0;
   logic pcm_clk = 1'b0, frame_sync = 1'b0, rx_line = 1'b0;
   logic dbl_rate = 1'b0, lin_mode = 1'b0;
   logic [5:0]  tx_slot_sel = '0, rx_slot_sel = '0;
   logic [15:0] tx_sample = '0;
   logic        tx_line, tx_line_oe, tx_busy_n, rx_strobe;
   logic [15:0] rx_sample;

   always #2 clk = ~clk;   // 250 MHz

   pcm_voice_port dut (
      .clk(clk), .rst_n(rst_n), .pcm_clk(pcm_clk), .frame_sync(frame_sync),
      .rx_line(rx_line), .dbl_rate(dbl_rate), .lin_mode(lin_mode),
      .tx_slot_sel(tx_slot_sel), .rx_slot_sel(rx_slot_sel), .tx_sample(tx_sample),
      .tx_line(tx_line), .tx_line_oe(tx_line_oe), .tx_busy_n(tx_busy_n),
      .rx_sample(rx_sample), .rx_strobe(rx_strobe));

   int tests = 0, fails = 0;
   int oecnt, busybad, idlebad, rx_cnt;
   logic [15:0] txcap, rx_got;

   always @(posedge clk) if (rx_strobe) begin rx_cnt++; rx_got = rx_sample; end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic bit en_of(input int slot, input bit lin);
      return lin ? (slot + 1 < MAXS) : (slot < MAXS);
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sample_tx();
      if (tx_busy_n == tx_line_oe) busybad++;
      if (!tx_line_oe && tx_line) idlebad++;
      if (tx_line_oe) begin txcap = {txcap[14:0], tx_line}; oecnt++; end
   endtask

   // One frame of nbits bit periods; rx window content taken from rw.
   task automatic run_frame(input int nbits, input bit dbl, input bit lin, input int rs,
                            input logic [15:0] rw, input bit with_fs, input int chg_at);
      int len = lin ? 16 : 8;
      bit ren = en_of(rs, lin);
      oecnt = 0; busybad = 0; idlebad = 0; rx_cnt = 0; txcap = '0;
      for (int b = 0; b < nbits; b++) begin
         logic rbit;
         rbit = b[0];
         if (ren && b >= rs * 8 && b < rs * 8 + len) rbit = rw[len - 1 - (b - rs * 8)];
         frame_sync = with_fs && (b == 0);
         rx_line = dbl ? ~rbit : rbit;
         pcm_clk = 1'b1; wait_clk(HALF);
         frame_sync = 1'b0;
         if (dbl) begin
            pcm_clk = 1'b0; wait_clk(HALF);
            rx_line = rbit;
            pcm_clk = 1'b1; wait_clk(HALF);
         end
         sample_tx();
         pcm_clk = 1'b0; wait_clk(HALF);
         if (b == chg_at) begin tx_sample = 16'hFFFF; tx_slot_sel = 6'd0; end
      end
   endtask

   typedef struct packed {
      logic        dbl;
      logic        lin;
      logic [5:0]  ts;
      logic [5:0]  rs;
      logic [15:0] tw;
      logic [15:0] rw;
      logic [10:0] nbits;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{1'b0, 1'b0, 6'd0,  6'd1,  16'h00A5, 16'h003C, 11'd64},
      '{1'b0, 1'b0, 6'd7,  6'd0,  16'h1281, 16'h007E, 11'd64},
      '{1'b1, 1'b0, 6'd2,  6'd5,  16'h00C3, 16'h0096, 11'd64},
      '{1'b0, 1'b1, 6'd3,  6'd5,  16'hBEEF, 16'h1234, 11'd64},
      '{1'b1, 1'b1, 6'd1,  6'd4,  16'h8001, 16'hF00D, 11'd64},
      '{1'b0, 1'b0, 6'd40, 6'd33, 16'h00FF, 16'h00AA, 11'd64},
      '{1'b0, 1'b1, 6'd31, 6'd30, 16'hCAFE, 16'h9BDF, 11'd256}
   };

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      wait_clk(5);
      check(tx_line_oe == 1'b0 && tx_busy_n == 1'b1 && tx_line == 1'b0 && rx_strobe == 1'b0,
            "R10 reset outputs", {tx_line_oe, tx_busy_n, tx_line, rx_strobe}, 4'b0100);
      rst_n = 1'b1;
      wait_clk(4);

      // R1: clocking with no frame sync must leave the port idle
      tx_slot_sel = 6'd0; rx_slot_sel = 6'd0; tx_sample = 16'h00FF;
      run_frame(24, 1'b0, 1'b0, 0, 16'h00FF, 1'b0, -1);
      check(oecnt == 0, "R1 no drive before frame sync", oecnt, 0);
      check(rx_cnt == 0, "R1 no strobe before frame sync", rx_cnt, 0);

      // Table walk: R2 R3 R4 R5 R6 R7 R8
      foreach (VECS[i]) begin
         vec_t v = VECS[i];
         bit ten = en_of(int'(v.ts), v.lin);
         bit ren = en_of(int'(v.rs), v.lin);
         int len = v.lin ? 16 : 8;
         logic [15:0] txe = v.lin ? v.tw : {8'h00, v.tw[7:0]};
         logic [15:0] rxe = v.lin ? v.rw : {8'h00, v.rw[7:0]};
         dbl_rate = v.dbl; lin_mode = v.lin;
         tx_slot_sel = v.ts; rx_slot_sel = v.rs; tx_sample = v.tw;
         run_frame(int'(v.nbits), v.dbl, v.lin, int'(v.rs), v.rw, 1'b1, -1);
         check(oecnt == (ten ? len : 0), "R2/R8 tx window length", oecnt, ten ? len : 0);
         if (ten) check(txcap == txe, "R2/R7 tx word MSB first", txcap, txe);
         check(busybad == 0 && idlebad == 0, "R3 busy/oe/idle line", busybad + idlebad, 0);
         check(rx_cnt == (ren ? 1 : 0), "R4/R8 rx strobe count", rx_cnt, ren ? 1 : 0);
         if (ren) check(rx_got == rxe, v.dbl ? "R6 rx word double rate" : "R5 rx word single rate",
                        rx_got, rxe);
      end

      // R9: mid-frame rewrite of sample and slot has no effect this frame
      dbl_rate = 1'b0; lin_mode = 1'b0;
      tx_slot_sel = 6'd1; rx_slot_sel = 6'd40; tx_sample = 16'h005A;
      run_frame(64, 1'b0, 1'b0, 40, 16'h0000, 1'b1, 4);
      check(txcap == 16'h005A, "R9 latched tx word", txcap, 16'h005A);
      check(oecnt == 8, "R9 latched tx slot", oecnt, 8);
      run_frame(64, 1'b0, 1'b0, 40, 16'h0000, 1'b1, -1);
      check(txcap == 16'h00FF && oecnt == 8, "R9 new values next frame", txcap, 16'h00FF);

      wait_clk(20);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule